// File: doc/BRIEF.md
# Card Multi-Block Transfer Sequencer

This block steps the data phase of a memory-card command that moves a series of fixed-size blocks between a host FIFO and the card. A command begins with a start pulse, which also latches the direction and the number of blocks. The block then waits for the command response and streams block data. When the FIFO cannot keep up, it holds the data path: on receive it holds while the FIFO is full, and on transmit it holds while the FIFO is empty.

After every block except the last, the sequencer stops at the block boundary and raises a request flag. Software then chooses one of two actions. To carry on, it writes both the continue strobe and the data-enable strobe, and these can arrive in any cycles. To end the sequence, it writes the abort strobe, and the card-side stop command is issued elsewhere. In auto mode, a block counter loaded at start replaces the per-block decision. After the last block of a transmit, the block waits in a data-busy state until the card releases its busy line, and it flags a timeout if the wait runs too long. Software reads progress from an eight-bit status byte.

Top module: `mcard_blk_seq`

## Requirements
- R1: In manual mode, a `blk_done` on a block that is not the last moves the sequencer to the boundary pause. While it is paused, status bit 0 (request) reads 1 and `data_run` is 0.
- R2: The pause is left only after both a continue strobe and a data-enable strobe have been seen, in the same cycle or in different ones. A single strobe of either kind leaves the sequencer paused. Both remembered strobes clear on leaving the pause, so the next boundary pauses again.
- R3: An abort strobe in any non-idle state returns the sequencer to idle on the next clock edge. The abort wins over continue and data-enable strobes in the same cycle. After the abort, status bits 7, 6, 5 and 0 read 0 and `data_run` is 0.
- R4: In auto mode, no block boundary pauses. The sequence completes on the `blk_done` that ends block number `cmd_blocks`.
- R5: In the transfer state, `data_run` is 0 during a receive while `fifo_full` is high, and 0 during a transmit while `fifo_empty` is high. It returns to 1 in the same cycle that the condition clears.
- R6: Status bit 7 (busy) reads 1 in the command-wait, transfer and pause states. It reads 0 in idle and in data-busy.
- R7: Status bit 6 is set when `fifo_full` is seen during a receive transfer. It stays set until a continue strobe arrives, the sequence completes, or the sequence is aborted.
- R8: Status bit 5 is set when `fifo_empty` is seen during a transmit transfer. It stays set until a data-enable strobe arrives, the sequence completes, or the sequence is aborted.
- R9: Status bit 4 reads 1 during a transmit transfer. A completed transmit enters data-busy, where status bit 3 reads 1, and it leaves data-busy for idle once `card_busy` is low.
- R10: Status bit 2 is set after `TMO_CYC` clock edges spent in data-busy. It stays set until the next command start.
- R11: After reset, the status byte is 0. Status bit 1 always reads 0.
- R12: In manual mode, a `blk_done` together with `last_blk` completes the sequence. A receive then goes straight to idle with no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for a command sequence, taken only in idle |
| cmd_rd | input | 1 | Direction latched at start: 1 means receive from the card |
| cmd_blocks | input | CNT_W | Block count latched at start, used in auto mode |
| auto_mode | input | 1 | Auto mode selection, latched at start |
| cmd_ack | input | 1 | Command response accepted |
| wr_conti | input | 1 | Continue strobe |
| wr_dataen | input | 1 | Data-enable strobe |
| wr_abort | input | 1 | Abort strobe |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| blk_done | input | 1 | Current block finished on the data path |
| last_blk | input | 1 | Finished block is the final one |
| card_busy | input | 1 | Card signals programming busy |
| data_run | output | 1 | Data path may move data this cycle |
| status | output | 8 | Status byte: 7 busy, 6 fifo full, 5 fifo empty, 4 write ready, 3 data busy, 2 busy timeout, 1 reserved, 0 request |

## Verification
Most internal faults show up in the status byte one edge after the stimulus that exposes them. A lost continue or data-enable memory keeps bit 0 set when the second strobe arrives. A stale memory clears bit 0 at the next boundary with no strobe at all. A wrong block counter in auto mode lets the sequence end one block early or late, so bit 7 falls at the wrong `blk_done`. A wrong timeout count moves the rise of bit 2 away from the `TMO_CYC`-th data-busy edge. Faults in the sticky FIFO bits appear either as a bit that fails to stay set after the flag drops, or as a bit that ignores the strobe meant to clear it.

// File: rtl/mcard_seq_pkg.sv
package mcard_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_XFER  = 3'd2,
        ST_PAUSE = 3'd3,
        ST_DBUSY = 3'd4
    } seq_state_e;

    localparam int unsigned SB_BUSY   = 7;
    localparam int unsigned SB_FFULL  = 6;
    localparam int unsigned SB_FEMPTY = 5;
    localparam int unsigned SB_WRRDY  = 4;
    localparam int unsigned SB_DBUSY  = 3;
    localparam int unsigned SB_TMO    = 2;
    localparam int unsigned SB_RSVD   = 1;
    localparam int unsigned SB_REQ    = 0;
    localparam int unsigned SB_WIDTH  = 8;

endpackage

// File: rtl/mcard_blk_cnt.sv
module mcard_blk_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (dec && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_one = (cnt_q.cnt == CNT_W'(1));
endmodule

// File: rtl/mcard_busy_tmr.sv
module mcard_busy_tmr #(
    parameter int unsigned TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tmo
);
    localparam int unsigned TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TMO_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LIMIT) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (run && (tmr_q.cnt == LIMIT)) begin
            tmr_d.flag = 1'b1;
        end
        if (clr) begin
            tmr_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tmo = tmr_q.flag;
endmodule

// File: rtl/mcard_stat_pack.sv
module mcard_stat_pack
    import mcard_seq_pkg::*;
(
    input  seq_state_e          state,
    input  logic                rd,
    input  logic                ffull,
    input  logic                fempty,
    input  logic                tmo,
    output logic [SB_WIDTH-1:0] status
);
    always_comb begin
        status            = '0;
        status[SB_BUSY]   = (state == ST_CMD) || (state == ST_XFER) || (state == ST_PAUSE);
        status[SB_FFULL]  = ffull;
        status[SB_FEMPTY] = fempty;
        status[SB_WRRDY]  = (state == ST_XFER) && !rd;
        status[SB_DBUSY]  = (state == ST_DBUSY);
        status[SB_TMO]    = tmo;
        status[SB_RSVD]   = 1'b0;
        status[SB_REQ]    = (state == ST_PAUSE);
    end
endmodule

// File: rtl/mcard_blk_seq.sv
module mcard_blk_seq
    import mcard_seq_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TMO_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_rd,
    input  logic [CNT_W-1:0] cmd_blocks,
    input  logic             auto_mode,
    input  logic             cmd_ack,
    input  logic             wr_conti,
    input  logic             wr_dataen,
    input  logic             wr_abort,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic             blk_done,
    input  logic             last_blk,
    input  logic             card_busy,
    output logic             data_run,
    output logic [7:0]       status
);
    typedef struct packed {
        seq_state_e state;
        logic       rd;
        logic       auto_m;
        logic       conti;
        logic       dataen;
        logic       ffull;
        logic       fempty;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic cnt_load, cnt_dec, cnt_one;
    logic tmr_run, tmr_clr, tmo;
    logic stall, finish;
    logic conti_q, dataen_q;

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        finish   = 1'b0;
        stall    = seq_q.rd ? fifo_full : fifo_empty;

        if (wr_conti)  seq_d.conti  = 1'b1;
        if (wr_dataen) seq_d.dataen = 1'b1;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    seq_d.state  = ST_CMD;
                    seq_d.rd     = cmd_rd;
                    seq_d.auto_m = auto_mode;
                    seq_d.conti  = 1'b0;
                    seq_d.dataen = 1'b0;
                    seq_d.ffull  = 1'b0;
                    seq_d.fempty = 1'b0;
                    cnt_load     = 1'b1;
                end
            end
            ST_CMD: begin
                if (cmd_ack) seq_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (seq_q.rd && fifo_full)   seq_d.ffull  = 1'b1;
                if (!seq_q.rd && fifo_empty) seq_d.fempty = 1'b1;
                if (blk_done) begin
                    cnt_dec = 1'b1;
                    if (last_blk || (seq_q.auto_m && cnt_one)) begin
                        finish = 1'b1;
                    end else if (!seq_q.auto_m) begin
                        seq_d.state = ST_PAUSE;
                    end
                end
            end
            ST_PAUSE: begin
                if ((seq_q.conti || wr_conti) && (seq_q.dataen || wr_dataen)) begin
                    seq_d.state  = ST_XFER;
                    seq_d.conti  = 1'b0;
                    seq_d.dataen = 1'b0;
                end
            end
            ST_DBUSY: begin
                if (!card_busy) seq_d.state = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase

        if (wr_conti)  seq_d.ffull  = 1'b0;
        if (wr_dataen) seq_d.fempty = 1'b0;

        if (finish) begin
            seq_d.state  = seq_q.rd ? ST_IDLE : ST_DBUSY;
            seq_d.ffull  = 1'b0;
            seq_d.fempty = 1'b0;
            seq_d.conti  = 1'b0;
            seq_d.dataen = 1'b0;
        end

        if (wr_abort && (seq_q.state != ST_IDLE)) begin
            seq_d.state  = ST_IDLE;
            seq_d.ffull  = 1'b0;
            seq_d.fempty = 1'b0;
            seq_d.conti  = 1'b0;
            seq_d.dataen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign tmr_run  = (seq_q.state == ST_DBUSY);
    assign tmr_clr  = (seq_q.state == ST_IDLE) && cmd_start;
    assign data_run = (seq_q.state == ST_XFER) && !stall;
    assign conti_q  = seq_q.conti;
    assign dataen_q = seq_q.dataen;

    mcard_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cmd_blocks),
        .dec      (cnt_dec),
        .at_one   (cnt_one)
    );

    mcard_busy_tmr #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .clr   (tmr_clr),
        .tmo   (tmo)
    );

    mcard_stat_pack u_stat (
        .state  (seq_q.state),
        .rd     (seq_q.rd),
        .ffull  (seq_q.ffull),
        .fempty (seq_q.fempty),
        .tmo    (tmo),
        .status (status)
    );
endmodule

// File: rtl/mcard_blk_seq_chk.sv
module mcard_blk_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       wr_abort,
    input logic       wr_conti,
    input logic       wr_dataen,
    input logic       fifo_full,
    input logic       conti_q,
    input logic       dataen_q,
    input logic       data_run,
    input logic [7:0] status
);
    assert_pause_holds_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !data_run);

    assert_resume_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status[0]) && !$past(wr_abort)) |->
            (($past(wr_conti) || $past(conti_q)) && ($past(wr_dataen) || $past(dataen_q))));

    assert_abort_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !cmd_start) |=> (!status[7] && !status[0] && !status[6] && !status[5] && !data_run));

    assert_busy_vs_dbusy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status[7], status[3]}));

    assert_full_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(fifo_full));

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] == 1'b0);
endmodule

bind mcard_blk_seq mcard_blk_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .wr_abort  (wr_abort),
    .wr_conti  (wr_conti),
    .wr_dataen (wr_dataen),
    .fifo_full (fifo_full),
    .conti_q   (conti_q),
    .dataen_q  (dataen_q),
    .data_run  (data_run),
    .status    (status)
);

// File: tb/mcard_blk_seq_test.sv
`timescale 1ns/1ps
module mcard_blk_seq_test;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned TMO_CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_rd = 0, auto_mode = 0, cmd_ack = 0;
    logic wr_conti = 0, wr_dataen = 0, wr_abort = 0;
    logic fifo_full = 0, fifo_empty = 0, blk_done = 0, last_blk = 0, card_busy = 0;
    logic [CNT_W-1:0] cmd_blocks = '0;
    logic data_run;
    logic [7:0] status;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp_st[$];
    logic       exp_run[$];
    string      exp_tag[$];

    always #2.5 clk = ~clk;

    mcard_blk_seq #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rd(cmd_rd),
        .cmd_blocks(cmd_blocks), .auto_mode(auto_mode), .cmd_ack(cmd_ack),
        .wr_conti(wr_conti), .wr_dataen(wr_dataen), .wr_abort(wr_abort),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .blk_done(blk_done),
        .last_blk(last_blk), .card_busy(card_busy), .data_run(data_run),
        .status(status)
    );

    // monitor: pops expected results half a cycle after the edge
    always @(negedge clk) begin
        if (exp_st.size() > 0) begin
            logic [7:0] st;
            logic       rn;
            string      tg;
            st = exp_st.pop_front();
            rn = exp_run.pop_front();
            tg = exp_tag.pop_front();
            n_tests++;
            if (status !== st || data_run !== rn) begin
                n_fail++;
                $display("FAIL %s: status=%02h data_run=%0b expected status=%02h data_run=%0b",
                         tg, status, data_run, st, rn);
            end
        end
    end

    // driver: one clock edge, then queue what must be seen after it
    task automatic tick(input logic [7:0] st, input logic rn, input string tg);
        @(posedge clk);
        exp_st.push_back(st);
        exp_run.push_back(rn);
        exp_tag.push_back(tg);
        @(negedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        cmd_start = 0; cmd_ack = 0; wr_conti = 0; wr_dataen = 0;
        wr_abort = 0; blk_done = 0; last_blk = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (status !== 8'h00 || data_run !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 in reset: status=%02h run=%0b expected 00 0", status, data_run);
        end
        #1 rst_n = 1'b1;
        tick(8'h00, 0, "R11 idle after reset");

        // manual receive, three blocks
        cmd_start = 1; cmd_rd = 1; cmd_blocks = 3;
        tick(8'h80, 0, "R6 command wait busy");
        clear_strobes();
        tick(8'h80, 0, "R6 waiting for ack");
        cmd_ack = 1;
        tick(8'h80, 1, "R5 transfer running");
        clear_strobes(); fifo_full = 1;
        tick(8'hC0, 0, "R5 R7 full stalls and sets bit6");
        fifo_full = 0;
        tick(8'hC0, 1, "R7 full sticky, R5 resume");
        blk_done = 1;
        tick(8'hC1, 0, "R1 boundary pause");
        clear_strobes(); wr_dataen = 1;
        tick(8'hC1, 0, "R2 data-enable alone stays paused");
        clear_strobes();
        tick(8'hC1, 0, "R2 still paused");
        wr_conti = 1;
        tick(8'h80, 1, "R2 R7 both seen resumes, continue clears bit6");
        clear_strobes(); blk_done = 1;
        tick(8'h81, 0, "R2 strobes self-cleared, pause again");
        clear_strobes(); wr_conti = 1; wr_dataen = 1;
        tick(8'h80, 1, "R2 same-cycle strobes resume");
        clear_strobes(); blk_done = 1; last_blk = 1;
        tick(8'h00, 0, "R12 last block completes receive");
        clear_strobes();

        // abort beats continue at a pause
        cmd_start = 1; cmd_blocks = 4;
        tick(8'h80, 0, "R6 restart");
        clear_strobes(); cmd_ack = 1;
        tick(8'h80, 1, "R5 transfer");
        clear_strobes(); blk_done = 1;
        tick(8'h81, 0, "R1 pause");
        clear_strobes(); wr_abort = 1; wr_conti = 1; wr_dataen = 1;
        tick(8'h00, 0, "R3 abort wins over continue");
        clear_strobes();

        // abort during a FIFO stall
        cmd_start = 1;
        tick(8'h80, 0, "R6 restart");
        clear_strobes(); cmd_ack = 1;
        tick(8'h80, 1, "R5 transfer");
        clear_strobes(); fifo_full = 1;
        tick(8'hC0, 0, "R5 R7 stall");
        wr_abort = 1;
        tick(8'h00, 0, "R3 abort in stall");
        clear_strobes(); fifo_full = 0;

        // auto transmit, two blocks, card stays busy
        auto_mode = 1; cmd_rd = 0; cmd_blocks = 2; card_busy = 1;
        cmd_start = 1;
        tick(8'h80, 0, "R6 auto start");
        clear_strobes(); cmd_ack = 1;
        tick(8'h90, 1, "R9 write ready");
        clear_strobes(); fifo_empty = 1;
        tick(8'hB0, 0, "R5 R8 empty stalls and sets bit5");
        fifo_empty = 0;
        tick(8'hB0, 1, "R8 empty sticky");
        wr_dataen = 1;
        tick(8'h90, 1, "R8 data-enable clears bit5");
        clear_strobes(); blk_done = 1;
        tick(8'h90, 1, "R4 auto no pause on block 1");
        tick(8'h08, 0, "R4 R9 completes after 2 blocks into data busy");
        clear_strobes();
        for (int i = 1; i < TMO_CYC; i++) begin
            tick(8'h08, 0, "R10 before timeout");
        end
        tick(8'h0C, 0, "R10 timeout raised");
        card_busy = 0;
        tick(8'h04, 0, "R9 busy release to idle, R10 held");
        cmd_start = 1;
        tick(8'h80, 0, "R10 start clears timeout");
        clear_strobes(); wr_abort = 1;
        tick(8'h00, 0, "R3 abort from command wait");
        clear_strobes();

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule